// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the serial side of an SPI master. It reads its setup from static configuration inputs: frame width, transfer direction, clock polarity and phase, bit order, slave-select timing, receive sample delay, clock divider and frame count. Once enabled it moves a programmed number of 8- or 16-bit frames. Transmit words come from a FIFO-style pop interface and received words leave through a push interface. The block drives the serial clock, the data-out line and up to two active-low slave selects, and it samples the data-in line.

A transfer starts on the first clock in which `en` is seen high. It runs frame by frame and then parks with `busy` low until `en` is dropped. A later transfer needs `en` high again. Dropping `en` at any point stops the engine at once. If the transmit side has no word ready, or the receive side has no room, the engine waits with the serial clock at its idle level, so no frame is lost.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset and whenever `busy` is low, all `ss_n` bits are high, `sclk` equals `cfg_cpol`, and `tx_pop` and `rx_push` are low.
- R2: The half period H, in clock cycles, is 1 when `cfg_div` is 0, 1 or 2, and `(cfg_div+1)/2` otherwise, so an odd divider acts as the next even one. Every serial clock half lasts exactly H cycles.
- R3: `cfg_wide`=0 gives 8-bit frames and `cfg_wide`=1 gives 16-bit frames. In 8-bit mode the received word sits in `rx_data[7:0]` and bits 15:8 are zero. In 8-bit mode only `tx_data[7:0]` is sent.
- R4: Each bit is a first half followed by a second half. In the first half `sclk` = `cfg_cpol ^ cfg_cpha`, and in the second half it is the inverse. Outside those halves `sclk` = `cfg_cpol`. `mosi` holds the bit through both halves, and the sample point is the start of the second half.
- R5: `cfg_lsb_first`=0 sends and receives the MSB first; `cfg_lsb_first`=1 sends and receives bit 0 first. In both cases `rx_data` holds the word with its natural bit weights.
- R6: `cfg_mode` 0 transmits and receives. `cfg_mode` 1 transmits only and never asserts `rx_push`. `cfg_mode` 2 receives only, never asserts `tx_pop`, and drives `mosi` low.
- R7: The selected `ss_n` bits (`cfg_sel`) go low for the first frame of a transfer, and for the first frame after each deassertion. They go low one fetch cycle after the frame is fetched, and stay low for H cycles (`cfg_setup`=0) or 2H cycles (`cfg_setup`=1) before the first clock half.
- R8: Between frames, `cfg_gap`=0 keeps the select low. `cfg_gap`=1 raises it for H cycles and `cfg_gap`=2 or 3 raises it for 2H cycles; in both cases one fetch cycle with the select still high follows, and then the R7 setup time.
- R9: Data-in is captured at the clock edge that ends the cycle `cfg_rsd` (0 to 3) cycles after the sample point. Each frame ends in a closing phase of max(H, `cfg_rsd`+1) − H + 1 idle cycles after its last half.
- R10: A transfer moves `cfg_frames`+1 frames. Each frame starts with a single fetch cycle, which carries the one-cycle `tx_pop` in transmitting modes. `busy` is high from the cycle after `en` is first seen until the closing phase of the last frame ends. After that, no new transfer starts while `en` stays high.
- R11: With `en` low at a clock edge, the next cycle has `busy` low and all `ss_n` high.
- R12: In a transmitting mode, with `tx_valid` low at a fetch, the engine waits in the fetch cycle: `sclk` stays idle, `busy` stays high and the select keeps its level. The engine resumes when a word arrives.
- R13: In a receiving mode, the engine neither fetches nor closes a frame while `rx_full` is high. The serial clock stays idle, and no received frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low aborts |
| cfg_wide | input | 1 | 0: 8-bit frames, 1: 16-bit frames |
| cfg_mode | input | 2 | 0 both ways, 1 transmit only, 2 receive only |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_setup | input | 1 | Select-to-clock delay: 0 H, 1 2H |
| cfg_gap | input | 2 | Inter-frame select release |
| cfg_rsd | input | 2 | Data-in sample delay in cycles |
| cfg_div | input | DIV_W | Clock divider |
| cfg_frames | input | CNT_W | Frame count minus one |
| cfg_sel | input | NSEL | Slaves to select |
| tx_data | input | 16 | Word at transmit FIFO head |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Take the head word |
| rx_data | output | 16 | Received word |
| rx_push | output | 1 | Write rx_data |
| rx_full | input | 1 | Receive FIFO has no room |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | NSEL | Active-low slave selects |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |

## Verification
The main function is tried with all four clock polarity and phase pairs. Across these runs the bench also mixes both frame widths and both bit orders, and it uses dividers of 0, 2, 3, 4 and 7, so rounding an odd divider up shows in the half length. Setup, gap and sample-delay settings are chosen so that a wrong half length, a missing fetch cycle or a misplaced select edge each shift the waveform by at least one cycle. Data-in carries the right bit only in its exact capture cycle, so a sample taken one cycle early or late corrupts the received word. Separate runs with an empty transmit side, a full receive side and an early abort check the waiting and stop behaviour.

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16,
  parameter int NSEL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_wide,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_setup,
  input  logic [1:0]       cfg_gap,
  input  logic [1:0]       cfg_rsd,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_frames,
  input  logic [NSEL-1:0]  cfg_sel,
  input  logic [15:0]      tx_data,
  input  logic             tx_valid,
  output logic             tx_pop,
  output logic [15:0]      rx_data,
  output logic             rx_push,
  input  logic             rx_full,
  output logic             sclk,
  output logic             mosi,
  output logic [NSEL-1:0]  ss_n,
  input  logic             miso,
  output logic             busy
);
  localparam int FW = 16;
  localparam int BW = $clog2(FW + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SETUP, S_A, S_B, S_FIN, S_GAP, S_DONE} st_t;

  st_t              st;
  logic [DIV_W:0]   cnt;
  logic [BW-1:0]    bitn, rcnt;
  logic [CNT_W-1:0] fcnt;
  logic [FW-1:0]    sh, rxs;
  logic [2:0]       spd;
  logic             ss_on;

  logic [DIV_W:0]   div_p1, half_m1, two_m1;
  logic [DIV_W-1:0] half;
  logic [BW-1:0]    nbits;
  logic             tx_need, rx_need, go, fin_ok, strobe, cap, lvl_a;

  assign div_p1  = {1'b0, cfg_div} + 1'b1;
  assign half    = (cfg_div <= DIV_W'(2)) ? DIV_W'(1) : div_p1[DIV_W:1];
  assign half_m1 = {1'b0, half} - 1'b1;
  assign two_m1  = {half, 1'b0} - 1'b1;

  assign nbits   = cfg_wide ? BW'(16) : BW'(8);
  assign tx_need = cfg_mode != 2'd2;
  assign rx_need = cfg_mode != 2'd1;
  assign go      = (!tx_need || tx_valid) && (!rx_need || !rx_full);
  assign fin_ok  = (rcnt == nbits) && (!rx_need || !rx_full);
  assign strobe  = (st == S_B) && (cnt == '0);
  assign lvl_a   = cfg_cpol ^ cfg_cpha;

  always_comb begin
    case (cfg_rsd)
      2'd0:    cap = strobe;
      2'd1:    cap = spd[0];
      2'd2:    cap = spd[1];
      default: cap = spd[2];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; rcnt <= '0; fcnt <= '0;
      sh <= '0; rxs <= '0; spd <= '0; ss_on <= 1'b0;
    end else if (!en) begin
      st <= S_IDLE; ss_on <= 1'b0; spd <= '0;
    end else begin
      spd <= {spd[1:0], strobe};
      case (st)
        S_IDLE: begin st <= S_LOAD; fcnt <= '0; end
        S_LOAD: if (go) begin
          sh <= tx_need ? tx_data : '0;
          bitn <= '0; rcnt <= '0; cnt <= '0;
          st <= ss_on ? S_A : S_SETUP;
          ss_on <= 1'b1;
        end
        S_SETUP: if (cnt == (cfg_setup ? two_m1 : half_m1)) begin
          cnt <= '0; st <= S_A;
        end else cnt <= cnt + 1'b1;
        S_A: if (cnt == half_m1) begin
          cnt <= '0; st <= S_B;
        end else cnt <= cnt + 1'b1;
        S_B: if (cnt == half_m1) begin
          cnt <= '0;
          sh <= cfg_lsb_first ? (sh >> 1) : (sh << 1);
          if (bitn == nbits - 1'b1) st <= S_FIN;
          else begin bitn <= bitn + 1'b1; st <= S_A; end
        end else cnt <= cnt + 1'b1;
        S_FIN: if (fin_ok) begin
          if (fcnt == cfg_frames) begin
            st <= S_DONE; ss_on <= 1'b0;
          end else begin
            fcnt <= fcnt + 1'b1;
            if (cfg_gap == 2'd0) st <= S_LOAD;
            else begin st <= S_GAP; ss_on <= 1'b0; cnt <= '0; end
          end
        end
        S_GAP: if (cnt == (cfg_gap[1] ? two_m1 : half_m1)) st <= S_LOAD;
               else cnt <= cnt + 1'b1;
        default: st <= S_DONE;
      endcase
      if (cap) begin
        rxs  <= cfg_lsb_first ? {miso, rxs[FW-1:1]} : {rxs[FW-2:0], miso};
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  assign busy    = (st != S_IDLE) && (st != S_DONE);
  assign sclk    = (st == S_A) ? lvl_a : (st == S_B) ? ~lvl_a : cfg_cpol;
  assign mosi    = cfg_lsb_first ? sh[0] : (cfg_wide ? sh[15] : sh[7]);
  assign ss_n    = ~(cfg_sel & {NSEL{ss_on}});
  assign tx_pop  = en && (st == S_LOAD) && go && tx_need;
  assign rx_push = en && (st == S_FIN) && fin_ok && rx_need;
  assign rx_data = cfg_wide ? rxs : (cfg_lsb_first ? {8'h00, rxs[15:8]} : {8'h00, rxs[7:0]});
endmodule

module spi_frame_engine_chk #(
  parameter int NSEL = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [1:0]      cfg_mode,
  input logic            cfg_cpol,
  input logic            tx_valid,
  input logic            tx_pop,
  input logic            rx_push,
  input logic            rx_full,
  input logic            sclk,
  input logic [NSEL-1:0] ss_n,
  input logic            busy
);
  p_idle_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ss_n == {NSEL{1'b1}});
  p_idle_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cfg_cpol);
  p_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == 2'd1 |-> !rx_push);
  p_no_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == 2'd2 |-> !tx_pop);
  p_pop_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  p_pop_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);
  p_push_room_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
endmodule

bind spi_frame_engine spi_frame_engine_chk #(.NSEL(NSEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol),
  .tx_valid(tx_valid), .tx_pop(tx_pop), .rx_push(rx_push), .rx_full(rx_full),
  .sclk(sclk), .ss_n(ss_n), .busy(busy)
);

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic cfg_wide = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_setup = 0;
  logic [1:0] cfg_mode = 0, cfg_gap = 0, cfg_rsd = 0;
  logic [15:0] cfg_div = 2, cfg_frames = 0;
  logic [1:0] cfg_sel = 2'b01;
  logic [15:0] tx_data, rx_data;
  logic tx_valid, tx_pop, rx_push, rx_full = 0, sclk, mosi, miso = 0, busy;
  logic [1:0] ss_n;

  logic [15:0] tx_mem [64];
  int tx_idx = 0, tx_avail = 64;
  logic tx_clr = 0;
  logic [15:0] got_rx[$], exp_rx[$];
  bit sched[int];
  int mc = 0, checks = 0, errors = 0;
  logic chk_on = 0, e_sclk = 0, e_ss = 0, e_busy = 0, e_mchk = 0, e_mosi = 0;
  string cur_tag = "";

  always #5 clk = ~clk;

  assign tx_data  = tx_mem[tx_idx[5:0]];
  assign tx_valid = tx_idx < tx_avail;

  always @(posedge clk) begin
    if (tx_clr) tx_idx <= 0;
    else if (tx_pop) tx_idx <= tx_idx + 1;
  end

  spi_frame_engine i_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wide(cfg_wide), .cfg_mode(cfg_mode),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_setup(cfg_setup), .cfg_gap(cfg_gap), .cfg_rsd(cfg_rsd), .cfg_div(cfg_div),
    .cfg_frames(cfg_frames), .cfg_sel(cfg_sel), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full),
    .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso), .busy(busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rx_push) got_rx.push_back(rx_data);
    if (chk_on)
      chk({cur_tag, " waveform {sclk,ss_n,busy,mosi}"},
          {27'd0, sclk, ss_n, busy, e_mchk ? mosi : 1'b0},
          {27'd0, e_sclk, e_ss ? ~cfg_sel : 2'b11, e_busy, e_mchk ? e_mosi : 1'b0});
  end

  task automatic step(input logic s, input logic ss, input logic b, input logic mc_en, input logic mv);
    @(posedge clk); #1;
    mc++;
    e_sclk = s; e_ss = ss; e_busy = b; e_mchk = mc_en; e_mosi = mv;
  endtask

  task automatic drive_miso();
    miso = sched.exists(mc) ? sched[mc] : logic'(((mc * 7) >> 1) & 1);
  endtask

  task automatic prep();
    @(negedge clk);
    tx_clr = 1;
    @(negedge clk);
    tx_clr = 0;
    got_rx.delete(); exp_rx.delete(); sched.delete(); mc = 0;
  endtask

  // Cycle-by-cycle reference model of one full transfer, built from R2-R10.
  task automatic run(input string tag);
    int h, n, l, nfr;
    logic lvl, ssp;
    logic [15:0] rxw [8];
    h   = (cfg_div <= 2) ? 1 : (int'(cfg_div) + 1) / 2;
    n   = cfg_wide ? 16 : 8;
    nfr = int'(cfg_frames) + 1;
    lvl = cfg_cpol ^ cfg_cpha;
    l   = ((int'(cfg_rsd) + 1 > h) ? int'(cfg_rsd) + 1 : h) - h + 1;
    for (int i = 0; i < 64; i++) tx_mem[i] = 16'($urandom);
    for (int i = 0; i < 8; i++) rxw[i] = cfg_wide ? 16'($urandom) : {8'h00, 8'($urandom)};
    tx_avail = 64;
    prep();
    cur_tag = tag;
    @(negedge clk);
    en = 1;
    ssp = 0;
    for (int f = 0; f < nfr; f++) begin
      logic [15:0] w;
      w = (cfg_mode == 2) ? 16'h0 : tx_mem[f];
      step(cfg_cpol, ssp, 1, 0, 0); drive_miso(); chk_on = 1;
      if (!ssp) repeat (cfg_setup ? 2 * h : h) begin step(cfg_cpol, 1, 1, 0, 0); drive_miso(); end
      ssp = 1;
      for (int b = 0; b < n; b++) begin
        logic tb, rb;
        tb = cfg_lsb_first ? w[b] : w[n-1-b];
        rb = cfg_lsb_first ? rxw[f][b] : rxw[f][n-1-b];
        repeat (h) begin step(lvl, 1, 1, 1, tb); drive_miso(); end
        for (int k = 0; k < h; k++) begin
          step(~lvl, 1, 1, 1, tb);
          if (k == 0) sched[mc + int'(cfg_rsd)] = rb;
          drive_miso();
        end
      end
      repeat (l) begin step(cfg_cpol, 1, 1, 0, 0); drive_miso(); end
      if (cfg_mode != 1) exp_rx.push_back(rxw[f]);
      if (f < nfr - 1 && cfg_gap != 0) begin
        repeat (cfg_gap[1] ? 2 * h : h) begin step(cfg_cpol, 0, 1, 0, 0); drive_miso(); end
        ssp = 0;
      end
    end
    repeat (6) step(cfg_cpol, 0, 0, 0, 0);
    @(negedge clk);
    chk_on = 0;
    en = 0;
    repeat (2) @(negedge clk);
    chk({tag, " R10 tx pops"}, tx_idx, (cfg_mode == 2) ? 0 : nfr);
    chk({tag, " R6 rx push count"}, got_rx.size(), exp_rx.size());
    for (int i = 0; i < exp_rx.size() && i < got_rx.size(); i++)
      chk({tag, " R5 rx word"}, got_rx[i], exp_rx[i]);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL R10 watchdog: run actual=unfinished expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int tog;
    for (int i = 0; i < 64; i++) tx_mem[i] = 16'(i * 37);
    repeat (3) @(negedge clk);
    chk("R1 reset outputs {ss_n,sclk,busy,pop,push}", {27'd0, ss_n, sclk, busy, tx_pop, rx_push}, {27'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0});
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, ss_n}, 32'd3);

    cfg_wide = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_div = 2;
    cfg_setup = 0; cfg_gap = 0; cfg_rsd = 0; cfg_mode = 0; cfg_frames = 2; cfg_sel = 2'b01;
    run("R3/R4 mode0 8b msb");

    cfg_wide = 1; cfg_cpol = 1; cfg_cpha = 1; cfg_lsb_first = 1; cfg_div = 3;
    cfg_setup = 1; cfg_gap = 1; cfg_rsd = 1; cfg_mode = 0; cfg_frames = 2; cfg_sel = 2'b10;
    run("R2/R5/R7/R8 mode3 16b lsb div3");

    cfg_wide = 0; cfg_cpol = 0; cfg_cpha = 1; cfg_lsb_first = 1; cfg_div = 4;
    cfg_setup = 0; cfg_gap = 2; cfg_rsd = 3; cfg_mode = 1; cfg_frames = 2; cfg_sel = 2'b11;
    run("R6/R8/R9 mode1 tx-only rsd3");

    cfg_wide = 1; cfg_cpol = 1; cfg_cpha = 0; cfg_lsb_first = 0; cfg_div = 0;
    cfg_setup = 1; cfg_gap = 0; cfg_rsd = 2; cfg_mode = 2; cfg_frames = 1; cfg_sel = 2'b01;
    run("R2/R6/R9 mode2 rx-only div0");

    cfg_wide = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_div = 7;
    cfg_setup = 0; cfg_gap = 1; cfg_rsd = 3; cfg_mode = 0; cfg_frames = 0; cfg_sel = 2'b01;
    run("R2/R9/R10 single frame div7");

    // R11: abort in mid-frame
    cfg_wide = 1; cfg_div = 4; cfg_frames = 3; cfg_mode = 0; cfg_sel = 2'b11;
    prep();
    en = 1;
    repeat (12) @(negedge clk);
    chk("R10 busy mid-transfer", busy, 1);
    en = 0;
    @(negedge clk);
    chk("R11 abort {busy,ss_n,sclk}", {28'd0, busy, ss_n, sclk}, {28'd0, 1'b0, 2'b11, cfg_cpol});
    repeat (3) @(negedge clk);

    // R12: transmit side runs dry after the first frame
    cfg_wide = 0; cfg_div = 2; cfg_frames = 1; cfg_gap = 0; cfg_rsd = 0; cfg_mode = 0; cfg_sel = 2'b01;
    prep();
    tx_avail = 1;
    en = 1;
    repeat (60) @(negedge clk);
    tog = 0;
    repeat (30) begin @(negedge clk); if (sclk !== cfg_cpol) tog++; end
    chk("R12 sclk idle while tx empty", tog, 0);
    chk("R12 busy while stalled", busy, 1);
    chk("R12 select held while stalled", ss_n, 2'b10);
    chk("R12 one frame done", got_rx.size(), 1);
    tx_avail = 2;
    wait_idle();
    chk("R12 resumed after word", got_rx.size(), 2);
    chk("R12 pops after resume", tx_idx, 2);
    en = 0;
    repeat (2) @(negedge clk);

    // R13: receive side full before the start
    cfg_frames = 0;
    prep();
    tx_avail = 64;
    rx_full = 1;
    en = 1;
    tog = 0;
    repeat (30) begin @(negedge clk); if (sclk !== cfg_cpol) tog++; end
    chk("R13 sclk idle while rx full", tog, 0);
    chk("R13 no pop while rx full", tx_idx, 0);
    chk("R13 busy while rx full", busy, 1);
    rx_full = 0;
    wait_idle();
    chk("R13 frame delivered after room", got_rx.size(), 1);
    en = 0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule